// File: doc/BRIEF.md
# Programmable-Order Integrator Chain with Decimation Capture

This block is the integrating half of a cascaded integrator-comb decimator. Five accumulators sit in series and advance together, once per accepted input sample. Each accumulator can have its feedback turned on or off, so the effective filter order (1 to 5) is chosen at run time. The accumulators get narrower along the chain: each stage keeps only the upper bits of the one before it, so precision that no longer matters is dropped as the sums grow.

A counter of accepted samples produces a capture enable on every HDEC-th sample, where HDEC is the programmed rate value plus one. On that enable, the last stage's contents are loaded into an output register, and a one-cycle valid pulse marks the new word. The capture runs on the same clock as the samples, gated by the enable. A bypass input zeroes every feedback path, which turns the chain into a pure delay line that still truncates.

Top module: `cic_integ_decim`

## Requirements
- R1: A synchronous active-low reset clears all five accumulators, the sample counter, the output word and the output valid. While reset is held, dec_o reads 0 and dec_vld_o reads 0.
- R2: The stage widths are 66, 56, 46, 36 and 26 bits. The input to stage k+1 is the top width(k+1) bits of stage k's register, with no rounding. All sums are two's complement and wrap at the stage width.
- R3: With order_i = N in 1..5, stages 1..N add their input to their own previous value. The other stages add zero, so they pass their input through with one sample of delay. The order values 0, 6 and 7 act as 5.
- R4: While bypass_i is 1, every stage adds zero regardless of order_i, so stage 1 holds exactly the last accepted sample.
- R5: HDEC = rate_i + 1, from 1 to 32. Counting accepted samples from reset, a capture is triggered by every HDEC-th sample. With rate_i = 0, every accepted sample triggers one.
- R6: The captured word equals the stage-5 register value just after the triggering sample has been accumulated.
- R7: dec_o changes only on the edge that raises dec_vld_o. dec_vld_o is high for exactly one cycle for each capture, two clock edges after the triggering sample is presented.
- R8: The chain and the counter advance only on cycles with smp_vld_i = 1. Idle cycles change neither the results nor the capture count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 66 | Signed input sample |
| smp_vld_i | input | 1 | Input sample accepted this cycle |
| order_i | input | 3 | Filter order (1..5; 0 and 6..7 act as 5) |
| bypass_i | input | 1 | Zero all stage feedback |
| rate_i | input | 5 | Decimation rate value; HDEC = rate_i + 1 |
| dec_o | output | 26 | Decimated output word |
| dec_vld_o | output | 1 | One-cycle pulse marking a new dec_o |

## Verification
The hardest case to reach from the ports is a capture that coincides with a still-moving pipeline. This happens when the triggering sample is followed straight away by another accepted sample, or by an idle gap, and the captured word has to reflect exactly the trigger sample's state of stage 5. The bench covers this by running impulse and step inputs with HDEC of 1, 4 and 32, including runs where the valid strobe has regular gaps. Every result is compared against a bit-accurate model of the truncating chain that is stepped once per accepted sample. A reset issued part-way through a run shows whether stale accumulator or counter state leaks into the next run.

// File: rtl/cic_pkg.sv
// Package: shared defaults for the programmable-order integrator chain.
// Assumes stage widths shrink by a fixed step from the first stage.
package cic_pkg;
    localparam int NSTG_DEF    = 5;
    localparam int W_FIRST_DEF = 66;
    localparam int W_STEP_DEF  = 10;
    localparam int RATE_W_DEF  = 5;

    // Width of the order field able to hold values 0..n
    function automatic int ord_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cic_order_dec.sv
// Order decoder: turns the run-time filter order and the bypass bit into
// one feedback enable per stage. Assumes order values outside 1..NSTG
// mean full order.
module cic_order_dec #(
    parameter int NSTG  = 5,
    parameter int ORD_W = 3
) (
    input  logic [ORD_W-1:0] order_i,
    input  logic             bypass_i,
    output logic [NSTG-1:0]  fb_en_o
);
    logic [ORD_W-1:0] ord_eff;

    // Clamp out-of-range orders to the full chain
    always_comb begin
        if (order_i == '0 || order_i > ORD_W'(NSTG))
            ord_eff = ORD_W'(NSTG);
        else
            ord_eff = order_i;
    end

    // Enable feedback on the first ord_eff stages unless bypassed
    always_comb begin
        for (int i = 0; i < NSTG; i++)
            fb_en_o[i] = !bypass_i && (ORD_W'(i) < ord_eff);
    end
endmodule

// File: rtl/cic_integ_stage.sv
// One integrator stage: adder feeding a register. With feedback enabled it
// adds the input to its own sum, otherwise it registers the input.
// Assumes din is already truncated to W bits; wraps at W bits.
module cic_integ_stage #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         fb_en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);
    // Accumulate or pass through on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (adv_i)
            q_o <= (fb_en_i ? q_o : '0) + din_i;
    end
endmodule

// File: rtl/cic_dec_ctrl.sv
// Decimation control: counts accepted samples and raises a registered
// capture enable one edge after every (rate_i+1)-th sample.
// Assumes rate_i is held steady during a run.
module cic_dec_ctrl #(
    parameter int RATE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              load_o
);
    logic [RATE_W-1:0] cnt_q;
    logic              hit;

    // Terminal count reached (>= guards against a lowered rate)
    always_comb hit = (cnt_q >= rate_i);

    // Sample counter and registered capture enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_o <= 1'b0;
        end else begin
            load_o <= adv_i && hit;
            if (adv_i)
                cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cic_integ_decim.sv
// Top: five truncating integrator stages of selectable order followed by
// a decimation register loaded from the last stage on every HDEC-th sample.
// Assumes order, bypass and rate are changed only while the chain is reset.
module cic_integ_decim
    import cic_pkg::*;
#(
    parameter int NSTG    = NSTG_DEF,
    parameter int W_FIRST = W_FIRST_DEF,
    parameter int W_STEP  = W_STEP_DEF,
    parameter int RATE_W  = RATE_W_DEF,
    parameter int ORD_W   = ord_width(NSTG_DEF),
    parameter int W_LAST  = W_FIRST - (NSTG - 1) * W_STEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W_FIRST-1:0] smp_i,
    input  logic               smp_vld_i,
    input  logic [ORD_W-1:0]   order_i,
    input  logic               bypass_i,
    input  logic [RATE_W-1:0]  rate_i,
    output logic [W_LAST-1:0]  dec_o,
    output logic               dec_vld_o
);
    logic [NSTG-1:0]    fb_en;
    logic               load;
    logic [W_FIRST-1:0] stage1_q;
    logic [W_LAST-1:0]  last_q;

    cic_order_dec #(.NSTG(NSTG), .ORD_W(ORD_W)) u_ord (
        .order_i (order_i),
        .bypass_i(bypass_i),
        .fb_en_o (fb_en)
    );

    cic_dec_ctrl #(.RATE_W(RATE_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (smp_vld_i),
        .rate_i(rate_i),
        .load_o(load)
    );

    for (genvar k = 0; k < NSTG; k++) begin : gen_stg
        localparam int WK = W_FIRST - k * W_STEP;
        logic [WK-1:0] din;
        logic [WK-1:0] q;
        if (k == 0) begin : g_head
            assign din = smp_i;
        end else begin : g_tail
            localparam int WP = W_FIRST - (k - 1) * W_STEP;
            assign din = gen_stg[k-1].q[WP-1 -: WK];
        end
        cic_integ_stage #(.W(WK)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (smp_vld_i),
            .fb_en_i(fb_en[k]),
            .din_i  (din),
            .q_o    (q)
        );
    end

    assign stage1_q = gen_stg[0].q;
    assign last_q   = gen_stg[NSTG-1].q;

    // Decimation register and its one-cycle valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_o     <= '0;
            dec_vld_o <= 1'b0;
        end else begin
            dec_vld_o <= load;
            if (load)
                dec_o <= last_q;
        end
    end
endmodule

// File: rtl/cic_integ_decim_chk.sv
// Checker for cic_integ_decim: port-level timing of captures and the
// behaviour of stage 1 under feedback and bypass. Bound to every instance.
module cic_integ_decim_chk #(
    parameter int W_FIRST = 66,
    parameter int W_LAST  = 26,
    parameter int RATE_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [W_FIRST-1:0] smp_i,
    input logic               smp_vld_i,
    input logic               bypass_i,
    input logic [RATE_W-1:0]  rate_i,
    input logic [W_LAST-1:0]  dec_o,
    input logic               dec_vld_o,
    input logic [W_FIRST-1:0] stage1_q
);
    // Stage 1 always accumulates when not bypassed
    assert_stage1_accum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && smp_vld_i) |=> (stage1_q == $past(stage1_q) + $past(smp_i)));

    // Under bypass stage 1 holds the last sample only
    assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && smp_vld_i) |=> (stage1_q == $past(smp_i)));

    // HDEC of 1: each sample yields a capture two edges later
    assert_hdec_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && rate_i == '0) |=> ##1 dec_vld_o);

    // A valid pulse always traces back to an accepted sample
    assert_vld_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && $past(rst_n, 2)) |-> $past(smp_vld_i, 2));

    // Output word moves only together with a valid pulse
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_vld_o && $past(rst_n)) |-> $stable(dec_o));
endmodule

bind cic_integ_decim cic_integ_decim_chk #(
    .W_FIRST(W_FIRST),
    .W_LAST (W_LAST),
    .RATE_W (RATE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_i    (smp_i),
    .smp_vld_i(smp_vld_i),
    .bypass_i (bypass_i),
    .rate_i   (rate_i),
    .dec_o    (dec_o),
    .dec_vld_o(dec_vld_o),
    .stage1_q (stage1_q)
);

// File: tb/cic_integ_decim_tb.sv
// Directed bench: impulse, step, bypass, gapped-valid and reset scenarios,
// each compared with a bit-accurate model stepped once per accepted sample.
module cic_integ_decim_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [65:0] smp = '0;
    logic        smp_vld = 1'b0;
    logic [2:0]  order = 3'd5;
    logic        bypass = 1'b0;
    logic [4:0]  rate = '0;
    logic [25:0] dec;
    logic        dec_vld;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R6";

    // Model state
    logic [65:0] m1;
    logic [55:0] m2;
    logic [45:0] m3;
    logic [35:0] m4;
    logic [25:0] m5;
    int          mcnt;
    logic [25:0] exp_mem [0:255];
    int          wr_i;
    int          rd_i;

    always #5 clk = ~clk;

    cic_integ_decim u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_i    (smp),
        .smp_vld_i(smp_vld),
        .order_i  (order),
        .bypass_i (bypass),
        .rate_i   (rate),
        .dec_o    (dec),
        .dec_vld_o(dec_vld)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Output monitor: each pulse must match the next expected word (R6, R7)
    always @(negedge clk) begin
        if (rst_n && dec_vld) begin
            total++;
            if (rd_i >= wr_i) begin
                bad++;
                $display("FAIL R7 %s: unexpected pulse, actual dec=%h expected no pulse", cur_req, dec);
            end else begin
                if (dec !== exp_mem[rd_i & 255]) begin
                    bad++;
                    $display("FAIL R6 %s: capture %0d actual=%h expected=%h",
                             cur_req, rd_i, dec, exp_mem[rd_i & 255]);
                end
                rd_i++;
            end
        end
    end

    function automatic logic [4:0] fb_mask(input logic [2:0] o, input logic b);
        int eff;
        logic [4:0] m;
        eff = (o == 0 || o > 5) ? 5 : int'(o);
        for (int i = 0; i < 5; i++) m[i] = !b && (i < eff);
        return m;
    endfunction

    // One accepted sample through the reference chain (R2, R3, R4, R5)
    task automatic model_step(input logic [65:0] x);
        logic [4:0] fb;
        fb = fb_mask(order, bypass);
        m5 = (fb[4] ? m5 : 26'd0) + m4[35:10];
        m4 = (fb[3] ? m4 : 36'd0) + m3[45:10];
        m3 = (fb[2] ? m3 : 46'd0) + m2[55:10];
        m2 = (fb[1] ? m2 : 56'd0) + m1[65:10];
        m1 = (fb[0] ? m1 : 66'd0) + x;
        if (mcnt >= int'(rate)) begin
            exp_mem[wr_i & 255] = m5;
            wr_i++;
            mcnt = 0;
        end else begin
            mcnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0;
        mcnt = 0; wr_i = 0; rd_i = 0;
        rst_n = 1'b1;
    endtask

    task automatic feed(input logic [65:0] x);
        smp = x;
        smp_vld = 1'b1;
        model_step(x);
        @(negedge clk);
    endtask

    task automatic idle();
        smp_vld = 1'b0;
        smp = 66'h2A5A5;
        @(negedge clk);
    endtask

    // Drain and check that every expected capture appeared (R5)
    task automatic finish_run(input string req);
        smp_vld = 1'b0;
        repeat (6) @(negedge clk);
        total++;
        if (rd_i != wr_i) begin
            bad++;
            $display("FAIL %s: capture count actual=%0d expected=%0d", req, rd_i, wr_i);
        end
    endtask

    // kind 0 impulse, 1 step; gap inserts idle cycles (R8)
    task automatic run_case(input int kind, input logic [2:0] o, input logic b,
                            input logic [4:0] r, input bit gap, input string req);
        int hd;
        logic [65:0] x;
        order = o; bypass = b; rate = r; cur_req = req;
        do_reset();
        hd = int'(r) + 1;
        for (int i = 0; i < hd * 3 + 6; i++) begin
            if (kind == 0) x = (i == 0) ? (66'd1 << 50) : 66'd0;
            else           x = -(66'd1 << 41);
            feed(x);
            if (gap && (i % 3 == 2)) begin
                idle();
                idle();
            end
        end
        finish_run(req);
    endtask

    // R1: outputs during and after reset
    task automatic test_reset();
        order = 3'd5; bypass = 1'b0; rate = 5'd0; cur_req = "R1";
        do_reset();
        feed(66'h3_FFFF_FFFF_FFFF_FFFF);
        feed(66'h1_2345_6789_ABCD_EF01);
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0;
        @(negedge clk);
        total++;
        if (dec !== 26'd0 || dec_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset outputs actual dec=%h vld=%b expected 0/0", dec, dec_vld);
        end
        rst_n = 1'b1;
        m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0;
        mcnt = 0; wr_i = 0; rd_i = 0;
        @(negedge clk);
        total++;
        if (dec !== 26'd0 || dec_vld !== 1'b0) begin
            bad++;
            $display("FAIL R1: after reset actual dec=%h vld=%b expected 0/0", dec, dec_vld);
        end
    endtask

    // R1: reset part-way clears stages and counter
    task automatic test_mid_reset();
        order = 3'd5; bypass = 1'b0; rate = 5'd3; cur_req = "R1";
        do_reset();
        feed(66'd1 << 55);
        feed(66'd1 << 55);
        feed(66'd1 << 55);
        do_reset();
        for (int i = 0; i < 20; i++) feed((i == 0) ? (66'd1 << 50) : 66'd0);
        finish_run("R1");
    endtask

    initial begin
        test_reset();
        test_mid_reset();
        // R3/R6: impulse and step, every order, HDEC 1, 4, 32
        for (int o = 1; o <= 5; o++) begin
            run_case(0, 3'(o), 1'b0, 5'd0,  1'b0, "R3 impulse");
            run_case(0, 3'(o), 1'b0, 5'd3,  1'b0, "R3 impulse");
            run_case(0, 3'(o), 1'b0, 5'd31, 1'b0, "R3 impulse");
            run_case(1, 3'(o), 1'b0, 5'd0,  1'b0, "R2 step");
            run_case(1, 3'(o), 1'b0, 5'd3,  1'b0, "R2 step");
            run_case(1, 3'(o), 1'b0, 5'd31, 1'b0, "R2 step");
        end
        // R3: out-of-range orders act as full order
        run_case(1, 3'd0, 1'b0, 5'd3, 1'b0, "R3 order0");
        run_case(1, 3'd7, 1'b0, 5'd3, 1'b0, "R3 order7");
        // R4: bypass turns the chain into a delay line
        run_case(1, 3'd5, 1'b1, 5'd0, 1'b0, "R4 bypass");
        run_case(0, 3'd3, 1'b1, 5'd3, 1'b0, "R4 bypass");
        // R8: idle cycles between samples
        run_case(1, 3'd5, 1'b0, 5'd3, 1'b1, "R8 gaps");
        run_case(0, 3'd4, 1'b0, 5'd0, 1'b1, "R8 gaps");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule